// File: doc/BRIEF.md
# Four-Phase Byte Handshake Port

This block moves bytes across a chip boundary with a two-wire, four-phase handshake. One wire is an active-low "byte present" strobe. The other is an active-high "ready" acknowledge. A direction input picks one of two roles.

In the receive role, the far side places a byte on the data pins and pulls the strobe low. The port captures the byte and drops ready. It keeps ready low until two things have happened: the strobe has gone high again, and the local processor has read the byte. A byte that has not been read therefore stalls the sender.

In the send role, the processor writes a byte and the port drives it onto the pins. One clock later the port lowers the strobe. It raises the strobe once the receiver pulls ready low. It accepts no new byte until ready has risen again.

Both incoming handshake wires pass through a synchronizer of parameterised depth before any state machine uses them. The port is used as a stand-alone byte channel beside a small processor. The processor polls the full and empty flags to decide when to read or write.

Top module: `strobe_port`

## Requirements
- R1: While reset is asserted, `rdy_out` is 0, `dav_n_out` is 1, `rx_full` is 0, `tx_empty` is 1, `overrun` is 0 and `pin_dout` is all zeros.
- R2: In receive mode (`dir_out`=0), when `dav_n_in` falls while `rdy_out` is 1, the byte on `pin_din` is captured. `rdy_out` falls and `rx_full` rises on the third rising clock edge after the fall, and `cpu_rdata` shows the byte from then on.
- R3: `rdy_out` is 0 whenever `rx_full` is 1. A cycle with `cpu_re`=1 clears `rx_full` at the next edge.
- R4: After a capture, `rdy_out` stays 0 until `dav_n_in` has been high long enough to pass the synchronizer. It rises on the third edge after `dav_n_in` rises, or on the edge that clears `rx_full` if that comes later.
- R5: `cpu_rdata` keeps the captured byte when `pin_din` changes after `rdy_out` has fallen.
- R6: In send mode (`dir_out`=1), a `cpu_we` cycle with `tx_empty`=1 puts `cpu_wdata` on `pin_dout` and clears `tx_empty` at the next edge. `dav_n_out` falls one edge after that, so the data leads the strobe by one clock.
- R7: `dav_n_out` returns high on the third edge after `rdy_in` falls. `tx_empty` returns to 1 on the third edge after `rdy_in` rises again, and `dav_n_out` cannot fall again before then.
- R8: A `cpu_we` cycle in send mode while `tx_empty`=0 leaves `pin_dout` unchanged and raises `overrun` for exactly the following cycle.
- R9: In receive mode, `dav_n_out` is held at 1 and `cpu_we` has no effect (`tx_empty` stays 1, `overrun` stays 0). In send mode, `rdy_out` is held at 0 and a low `dav_n_in` captures nothing (`rx_full` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_out | input | 1 | 0 = receive role, 1 = send role |
| cpu_wdata | input | DATA_W | Byte to send |
| cpu_we | input | 1 | Write strobe for `cpu_wdata` |
| cpu_re | input | 1 | Read acknowledge; clears `rx_full` |
| cpu_rdata | output | DATA_W | Last received byte |
| rx_full | output | 1 | Received byte waiting to be read |
| tx_empty | output | 1 | Send side idle and able to take a byte |
| overrun | output | 1 | One-cycle pulse for an ignored write |
| pin_din | input | DATA_W | Incoming data pins |
| dav_n_in | input | 1 | Incoming active-low byte-present strobe |
| rdy_out | output | 1 | Outgoing ready acknowledge |
| pin_dout | output | DATA_W | Outgoing data pins |
| dav_n_out | output | 1 | Outgoing active-low byte-present strobe |
| rdy_in | input | 1 | Incoming ready acknowledge |

## Verification
The bench builds the port with its defaults: an 8-bit data path and a two-stage synchronizer. With 8 bits, every one of the 256 byte codes can be carried through a full four-phase exchange in each direction. With two stages, each handshake phase has a fixed three-edge latency, which the bench checks edge by edge. The sweeps also exercise a stalled read with the strobe still low, a write that arrives while a byte is still pending, and stimulus on the wires of whichever role is inactive.

// File: rtl/hsp_pkg.sv
package hsp_pkg;
  typedef enum logic [0:0] {RX_WAIT, RX_HOLD} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SETUP, TX_STROBE, TX_RELEASE} tx_state_e;
endpackage

// File: rtl/hsp_sync.sv
module hsp_sync #(
  parameter int   W       = 1,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [W-1:0] src;
    if (g == 0) begin : g_first
      assign src = d;
    end else begin : g_rest
      assign src = stg[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[g] <= {W{RST_VAL}};
      else        stg[g] <= src;
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/hsp_rx.sv
module hsp_rx
  import hsp_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         dav_n_pin,
  input  logic [W-1:0] din,
  input  logic         rd,
  output logic [W-1:0] data,
  output logic         full,
  output logic         rdy
);
  logic      dav_s_n;
  rx_state_e state_q, state_d;
  logic      full_q, full_d;
  logic      rdy_q, rdy_d;
  logic [W-1:0] data_q;
  logic      cap;

  hsp_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_dav_sync (
    .clk(clk), .rst_n(rst_n), .d(dav_n_pin), .q(dav_s_n)
  );

  // capture only when ready is offered and the synchronized strobe is low
  assign cap = en && (state_q == RX_WAIT) && !full_q && !dav_s_n;

  always_comb begin
    state_d = state_q;
    full_d  = full_q;
    case (state_q)
      RX_WAIT: if (cap)     state_d = RX_HOLD;
      RX_HOLD: if (dav_s_n) state_d = RX_WAIT;
      default:              state_d = RX_WAIT;
    endcase
    if (rd)  full_d = 1'b0;
    if (cap) full_d = 1'b1;
    if (!en) begin
      state_d = RX_WAIT;
      full_d  = 1'b0;
    end
    rdy_d = en && (state_d == RX_WAIT) && !full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_WAIT;
      full_q  <= 1'b0;
      rdy_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      full_q  <= full_d;
      rdy_q   <= rdy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   data_q <= '0;
    else if (cap) data_q <= din;
  end

  assign data = data_q;
  assign full = full_q;
  assign rdy  = rdy_q;

  // R4: while the sender still holds its strobe phase, ready is never offered
  a_r4_hold_keeps_rdy_low: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == RX_HOLD) |-> !rdy_q);
endmodule

// File: rtl/hsp_tx.sv
module hsp_tx
  import hsp_pkg::*;
#(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] wdata,
  input  logic         we,
  input  logic         rdy_pin,
  output logic [W-1:0] dout,
  output logic         dav_n,
  output logic         empty,
  output logic         ovr
);
  logic      rdy_s;
  tx_state_e state_q, state_d;
  logic      dav_n_q, dav_n_d;
  logic      ovr_q, ovr_d;
  logic [W-1:0] dout_q;
  logic      load;

  hsp_sync #(.W(1), .STAGES(STAGES), .RST_VAL(1'b1)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(rdy_pin), .q(rdy_s)
  );

  assign load  = en && we && (state_q == TX_IDLE);
  assign ovr_d = en && we && (state_q != TX_IDLE);

  always_comb begin
    state_d = state_q;
    case (state_q)
      TX_IDLE:    if (load)   state_d = TX_SETUP;
      TX_SETUP:               state_d = TX_STROBE;
      TX_STROBE:  if (!rdy_s) state_d = TX_RELEASE;
      TX_RELEASE: if (rdy_s)  state_d = TX_IDLE;
      default:                state_d = TX_IDLE;
    endcase
    if (!en) state_d = TX_IDLE;
    dav_n_d = (state_d != TX_STROBE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      dav_n_q <= 1'b1;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      dav_n_q <= dav_n_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    dout_q <= '0;
    else if (load) dout_q <= wdata;
  end

  assign dout  = dout_q;
  assign dav_n = dav_n_q;
  assign empty = (state_q == TX_IDLE);
  assign ovr   = ovr_q;

  // R7: the strobe is released only after the receiver's ready was seen low
  a_r7_release_after_rdy_low: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(dav_n_q) && $past(en)) |-> $past(!rdy_s));
endmodule

// File: rtl/strobe_port.sv
module strobe_port #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dir_out,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_we,
  input  logic              cpu_re,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              rx_full,
  output logic              tx_empty,
  output logic              overrun,
  input  logic [DATA_W-1:0] pin_din,
  input  logic              dav_n_in,
  output logic              rdy_out,
  output logic [DATA_W-1:0] pin_dout,
  output logic              dav_n_out,
  input  logic              rdy_in
);
  logic rx_en, tx_en;

  assign rx_en = !dir_out;
  assign tx_en =  dir_out;

  hsp_rx #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .en(rx_en), .dav_n_pin(dav_n_in), .din(pin_din),
    .rd(cpu_re), .data(cpu_rdata), .full(rx_full), .rdy(rdy_out)
  );

  hsp_tx #(.W(DATA_W), .STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst_n(rst_n), .en(tx_en), .wdata(cpu_wdata), .we(cpu_we),
    .rdy_pin(rdy_in), .dout(pin_dout), .dav_n(dav_n_out), .empty(tx_empty),
    .ovr(overrun)
  );

  // R3: a waiting byte always throttles the sender
  a_r3_full_blocks_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    rx_full |-> !rdy_out);

  // R2: with receive role held, ready only drops because a byte was captured
  a_r2_drop_means_capture: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(rdy_out) && !$past(dir_out) && !dir_out) |-> rx_full);

  // R6: data is already on the pins when the strobe falls
  a_r6_data_leads_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dav_n_out) |-> ($stable(pin_dout) && !tx_empty));

  // R8: pending data never changes
  a_r8_pending_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_empty && $past(!tx_empty)) |-> $stable(pin_dout));

  // R8: an overrun pulse follows a write made in send role
  a_r8_overrun_source: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> ($past(cpu_we) && $past(dir_out)));

  // R9: the inactive role keeps its outgoing handshake wire quiet
  a_r9_rx_role_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(dir_out) |-> (dav_n_out && !overrun));
  a_r9_tx_role_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $past(dir_out) |-> !rdy_out);
endmodule

// File: tb/strobe_port_tb.sv
module strobe_port_tb;
  localparam int W = 8;

  logic         clk;
  logic         rst_n;
  logic         dir_out;
  logic [W-1:0] cpu_wdata;
  logic         cpu_we;
  logic         cpu_re;
  logic [W-1:0] cpu_rdata;
  logic         rx_full;
  logic         tx_empty;
  logic         overrun;
  logic [W-1:0] pin_din;
  logic         dav_n_in;
  logic         rdy_out;
  logic [W-1:0] pin_dout;
  logic         dav_n_out;
  logic         rdy_in;

  int checks = 0;
  int errors = 0;

  strobe_port #(.DATA_W(W), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_out(dir_out), .cpu_wdata(cpu_wdata),
    .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata), .rx_full(rx_full),
    .tx_empty(tx_empty), .overrun(overrun), .pin_din(pin_din), .dav_n_in(dav_n_in),
    .rdy_out(rdy_out), .pin_dout(pin_dout), .dav_n_out(dav_n_out), .rdy_in(rdy_in)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // receive one byte; R2 latency, R5 hold, R3 throttle and clear
  task automatic rx_byte(input logic [W-1:0] b);
    pin_din  = b;
    dav_n_in = 1'b0;
    step(2);
    chk("R2", "rdy before third edge", int'(rdy_out), 1);
    step(1);
    chk("R2", "rdy after capture", int'(rdy_out), 0);
    chk("R2", "full after capture", int'(rx_full), 1);
    chk("R2", "captured byte", int'(cpu_rdata), int'(b));
    pin_din  = ~b;
    dav_n_in = 1'b1;
    step(5);
    chk("R5", "byte held after pin change", int'(cpu_rdata), int'(b));
    chk("R3", "rdy low while full", int'(rdy_out), 0);
    cpu_re = 1'b1;
    step(1);
    cpu_re = 1'b0;
    chk("R3", "full cleared by read", int'(rx_full), 0);
    chk("R4", "rdy back after read", int'(rdy_out), 1);
  endtask

  // send one byte; R6 ordering, R7 release, optional R8 overrun
  task automatic tx_byte(input logic [W-1:0] b, input bit try_overrun);
    cpu_wdata = b;
    cpu_we    = 1'b1;
    step(1);
    cpu_we    = 1'b0;
    chk("R6", "data on pins", int'(pin_dout), int'(b));
    chk("R6", "strobe still high during setup", int'(dav_n_out), 1);
    chk("R6", "empty cleared", int'(tx_empty), 0);
    step(1);
    chk("R6", "strobe low one clock later", int'(dav_n_out), 0);
    if (try_overrun) begin
      cpu_wdata = ~b;
      cpu_we    = 1'b1;
      step(1);
      cpu_we    = 1'b0;
      chk("R8", "overrun pulse", int'(overrun), 1);
      chk("R8", "data unchanged", int'(pin_dout), int'(b));
      step(1);
      chk("R8", "overrun one cycle", int'(overrun), 0);
    end
    rdy_in = 1'b0;
    step(2);
    chk("R7", "strobe held before third edge", int'(dav_n_out), 0);
    step(1);
    chk("R7", "strobe released", int'(dav_n_out), 1);
    chk("R7", "not empty while ready low", int'(tx_empty), 0);
    rdy_in = 1'b1;
    step(2);
    chk("R7", "still pending before third edge", int'(tx_empty), 0);
    step(1);
    chk("R7", "empty after ready high", int'(tx_empty), 1);
    chk("R7", "strobe stays high", int'(dav_n_out), 1);
  endtask

  initial begin
    #(1_000_000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    dir_out   = 1'b0;
    cpu_wdata = '0;
    cpu_we    = 1'b0;
    cpu_re    = 1'b0;
    pin_din   = '0;
    dav_n_in  = 1'b1;
    rdy_in    = 1'b1;
    step(3);
    // R1 reset state
    chk("R1", "rdy_out", int'(rdy_out), 0);
    chk("R1", "dav_n_out", int'(dav_n_out), 1);
    chk("R1", "rx_full", int'(rx_full), 0);
    chk("R1", "tx_empty", int'(tx_empty), 1);
    chk("R1", "overrun", int'(overrun), 0);
    chk("R1", "pin_dout", int'(pin_dout), 0);
    rst_n = 1'b1;
    step(1);
    chk("R2", "ready offered after reset", int'(rdy_out), 1);

    // receive sweep over all byte codes
    for (int i = 0; i < 256; i++) rx_byte(W'(i));

    // R4: read early while the strobe is still low
    pin_din  = 8'hC3;
    dav_n_in = 1'b0;
    step(3);
    chk("R4", "captured", int'(rx_full), 1);
    cpu_re = 1'b1;
    step(1);
    cpu_re = 1'b0;
    chk("R4", "full cleared", int'(rx_full), 0);
    chk("R4", "rdy low while strobe low", int'(rdy_out), 0);
    step(3);
    chk("R4", "rdy still low", int'(rdy_out), 0);
    dav_n_in = 1'b1;
    step(2);
    chk("R4", "rdy low before third edge", int'(rdy_out), 0);
    step(1);
    chk("R4", "rdy high after strobe release", int'(rdy_out), 1);

    // R9: writes in receive role
    cpu_wdata = 8'h5A;
    cpu_we    = 1'b1;
    step(1);
    cpu_we    = 1'b0;
    step(1);
    chk("R9", "tx_empty in rx role", int'(tx_empty), 1);
    chk("R9", "overrun in rx role", int'(overrun), 0);
    chk("R9", "dav_n_out in rx role", int'(dav_n_out), 1);
    chk("R9", "pin_dout untouched", int'(pin_dout), 0);

    // switch to send role
    dir_out = 1'b1;
    step(1);
    chk("R9", "rdy_out held low in tx role", int'(rdy_out), 0);
    dav_n_in = 1'b0;
    pin_din  = 8'h99;
    step(5);
    chk("R9", "no capture in tx role", int'(rx_full), 0);
    chk("R9", "rdy_out still low", int'(rdy_out), 0);
    dav_n_in = 1'b1;
    step(4);

    // send sweep over all byte codes, overrun on every sixteenth
    for (int i = 0; i < 256; i++) tx_byte(W'(255 - i), (i % 16) == 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule